// File: doc/BRIEF.md
# Two-Wire Register Slave with Auto-Increment

This block is a slave on a two-wire serial bus (clock line plus open-drain data line) that gives a bus host byte access to a 256-entry internal register file. It oversamples both bus lines in the system clock domain, cleans them up, and detects START, STOP and clock edges. It then answers its own 7-bit device address, takes a register index (sub-address), and moves a run of data bytes in or out. After each byte the index steps on by one.

The device address is fixed in its upper six bits. Its lowest bit comes from a strap input, so two instances can share one bus. Reads use the usual combined format: a write phase that sets the index, a repeated START, then the address with the read bit set. The register file also has a separate parallel read port, which lets the pixel datapath pick up settings without using the bus.

Top module: `twowire_regslave`

## Requirements
- R1: While `rst` is high the slave keeps `sda_oe_o` low and acknowledges nothing; it responds only to transfers that start after reset is released.
- R2: The slave acknowledges (pulls SDA low during the 9th clock) an address byte whose upper seven bits are 0x46 when `addr_sel_i` is 0, or 0x47 when it is 1; bit 0 of that byte is the direction (0 write, 1 read).
- R3: In a write, the byte after the address is the register index. Each following byte is stored at the current index and acknowledged by the slave. `rd_data_o` shows the entry chosen by `rd_addr_i` one clock later.
- R4: The index advances by one after every data byte, so several consecutive bytes land in consecutive registers.
- R5: After a repeated START and the address with the read bit, the slave sends the entry at the current index MSB first. It advances the index after each byte and keeps sending while the host acknowledges.
- R6: The index wraps from 0xFF to 0x00, for both writes and reads.
- R7: An address that does not match gets no acknowledge. The slave then stays silent and changes no register until the next START or STOP.
- R8: A START in any state abandons the transfer in progress, discards a partly received byte, and begins a new address reception.
- R9: A pulse on either bus line that lasts fewer than three system clocks is ignored: it causes no clock edge, START or STOP.
- R10: The slave only pulls SDA low or releases it. After the host refuses a read byte (NACK), the slave releases SDA so the host can issue STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run well above the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| addr_sel_i | input | 1 | Strap that selects the lowest device-address bit |
| sda_oe_o | output | 1 | High pulls SDA low; low releases it |
| rd_addr_i | input | 8 | Parallel read port index |
| rd_data_o | output | 8 | Parallel read port data, one clock after the index |

## Verification
A serial write to a register and a parallel read of that same register can fall in the same clock cycle. The bench parks `rd_addr_i` on the index a write transaction is about to fill, so the storage cycle and the port read coincide. The port must first show the old value and then the new one one clock later. The bench checks the settled value after the transaction and compares it with its model. Serial reads go through a scoreboard queue, which confirms that increment and wrap stay correct on the path the datapath does not see.

// File: rtl/twr_pkg.sv
package twr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RMACK,
    ST_IGNORE
  } twr_state_e;
endpackage

// File: rtl/twr_pin_filter.sv
module twr_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   level_q;
  logic                   sync_last;

  assign sync_last = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '1;
      hist_q  <= '1;
      level_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_last};
      if (&hist_q)       level_q <= 1'b1;
      else if (~|hist_q) level_q <= 1'b0;
    end
  end

  assign level_o = level_q;

  // A change of the clean level needs the synchronised pin to have held that value
  AST_FILT_AGREE: assert property (@(posedge clk) disable iff (rst)
    !$stable(level_q) |-> ($past(sync_last, 2) == level_q && $past(sync_last, 3) == level_q)); // R9
endmodule

// File: rtl/twr_bus_events.sv
module twr_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d   <= 1'b1;
      sda_d   <= 1'b1;
      start_o <= 1'b0;
      stop_o  <= 1'b0;
      rise_o  <= 1'b0;
      fall_o  <= 1'b0;
    end else begin
      scl_d   <= scl_f;
      sda_d   <= sda_f;
      start_o <= scl_f & scl_d & sda_d & ~sda_f;
      stop_o  <= scl_f & scl_d & ~sda_d & sda_f;
      rise_o  <= scl_f & ~scl_d;
      fall_o  <= ~scl_f & scl_d;
    end
  end
endmodule

// File: rtl/twr_regfile.sv
module twr_regfile #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_a_o <= mem[raddr_a_i];
    rdata_b_o <= mem[raddr_b_i];
  end
endmodule

// File: rtl/twr_engine.sv
module twr_engine
  import twr_pkg::*;
#(
  parameter int          AW      = 8,
  parameter logic [5:0]  ADDR_HI = 6'h23
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_f,
  input  logic          sda_f,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          addr_sel_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] ptr_o,
  output logic          we_o,
  output logic [7:0]    wdata_o,
  output logic          sda_oe_o
);
  localparam logic [3:0] BITS = 4'd8;

  twr_state_e    state;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic [7:0]    tx;
  logic [AW-1:0] ptr;
  logic          rw, more, sda_oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      tx     <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      more   <= 1'b0;
      sda_oe <= 1'b0;
      we_o   <= 1'b0;
      wdata_o <= '0;
    end else begin
      we_o <= 1'b0;
      if (start_i) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_i) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (rise_i && bitcnt != BITS) begin
              shreg  <= {shreg[6:0], sda_f};
              bitcnt <= bitcnt + 4'd1;
            end else if (fall_i && bitcnt == BITS) begin
              bitcnt <= '0;
              case (state)
                ST_ADDR: begin
                  if (shreg[7:1] == {ADDR_HI, addr_sel_i}) begin
                    sda_oe <= 1'b1;
                    rw     <= shreg[0];
                    state  <= ST_ADDR_ACK;
                  end else begin
                    state  <= ST_IGNORE;
                  end
                end
                ST_SUB: begin
                  sda_oe <= 1'b1;
                  ptr    <= shreg[AW-1:0];
                  state  <= ST_SUB_ACK;
                end
                default: begin
                  sda_oe  <= 1'b1;
                  we_o    <= 1'b1;
                  wdata_o <= shreg;
                  state   <= ST_WDATA_ACK;
                end
              endcase
            end
          end
          ST_ADDR_ACK: begin
            if (fall_i) begin
              if (rw) begin
                tx     <= rd_data_i;
                sda_oe <= ~rd_data_i[7];
                bitcnt <= '0;
                state  <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_SUB;
              end
            end
          end
          ST_SUB_ACK: begin
            if (fall_i) begin
              sda_oe <= 1'b0;
              state  <= ST_WDATA;
            end
          end
          ST_WDATA_ACK: begin
            if (fall_i) begin
              sda_oe <= 1'b0;
              ptr    <= ptr + AW'(1);
              state  <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (rise_i) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (fall_i) begin
              if (bitcnt == BITS) begin
                sda_oe <= 1'b0;
                ptr    <= ptr + AW'(1);
                bitcnt <= '0;
                state  <= ST_RMACK;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          ST_RMACK: begin
            if (rise_i) begin
              more <= ~sda_f;
            end else if (fall_i) begin
              if (more) begin
                tx     <= rd_data_i;
                sda_oe <= ~rd_data_i[7];
                state  <= ST_RDATA;
              end else begin
                state  <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_o    = ptr;
  assign sda_oe_o = sda_oe;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !sda_oe); // R1
  AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE) |-> !sda_oe); // R7
  AST_PULL_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_f); // R10
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WDATA_ACK && fall_i && !start_i && !stop_i) |=> (ptr == $past(ptr) + AW'(1))); // R4
endmodule

// File: rtl/twowire_regslave.sv
module twowire_regslave #(
  parameter int         REG_AW      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  parameter logic [5:0] ADDR_HI     = 6'h23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  output logic              sda_oe_o,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] pins_raw, pins_flt;
  logic start, stop, rise, fall;
  logic we;
  logic [7:0] wdata, eng_rdata;
  logic [REG_AW-1:0] ptr;

  assign pins_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    twr_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_flt (
      .clk(clk), .rst(rst), .pin_i(pins_raw[g]), .level_o(pins_flt[g]));
  end

  twr_bus_events u_evt (
    .clk(clk), .rst(rst), .scl_f(pins_flt[0]), .sda_f(pins_flt[1]),
    .start_o(start), .stop_o(stop), .rise_o(rise), .fall_o(fall));

  twr_engine #(.AW(REG_AW), .ADDR_HI(ADDR_HI)) u_eng (
    .clk(clk), .rst(rst), .scl_f(pins_flt[0]), .sda_f(pins_flt[1]),
    .start_i(start), .stop_i(stop), .rise_i(rise), .fall_i(fall),
    .addr_sel_i(addr_sel_i), .rd_data_i(eng_rdata), .ptr_o(ptr),
    .we_o(we), .wdata_o(wdata), .sda_oe_o(sda_oe_o));

  twr_regfile #(.AW(REG_AW), .DW(8)) u_rf (
    .clk(clk), .we_i(we), .waddr_i(ptr), .wdata_i(wdata),
    .raddr_a_i(rd_addr_i), .rdata_a_o(rd_data_o),
    .raddr_b_i(ptr), .rdata_b_o(eng_rdata));
endmodule

// File: tb/twowire_regslave_test.sv
module twowire_regslave_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  QTR = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic sda_oe;
  logic sda_line;

  int checks = 0, errors = 0;
  logic [7:0] model [256];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] got;
  event       rd_ev;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  twowire_regslave uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .addr_sel_i(strap),
    .sda_oe_o(sda_oe), .rd_addr_i(rd_addr), .rd_data_o(rd_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i];
      if (glitch) begin
        repeat (4) @(negedge clk);
        scl_m = 1'b1; repeat (2) @(negedge clk); scl_m = 1'b0;
      end
      q(); scl_m = 1'b1; q();
      if (glitch) begin
        sda_m = ~b[i]; repeat (2) @(negedge clk); sda_m = b[i];
      end
      q(); scl_m = 1'b0; q();
    end
  endtask

  task automatic write_byte(input logic [7:0] b, input bit glitch, output bit ack);
    send_bits(b, 8, glitch);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = ~sda_line; q(); scl_m = 1'b0; q();
  endtask

  task automatic read_byte(input bit m_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl_m = 1'b1; q(); b[i] = sda_line; q(); scl_m = 1'b0; q();
    end
    sda_m = ~m_ack; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask

  function automatic logic [7:0] dev(input bit rd);
    return {6'h23, strap, rd};
  endfunction

  task automatic write_txn(input logic [7:0] sub, input int n, input logic [7:0] seed);
    bit ack;
    logic [7:0] d;
    rd_addr = sub;
    bus_start();
    write_byte(dev(0), 0, ack); chk(ack, "R2 address ack", ack, 1);
    write_byte(sub, 0, ack);    chk(ack, "R3 sub-address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      d = seed ^ 8'(i * 37);
      write_byte(d, 0, ack);    chk(ack, "R3 data ack", ack, 1);
      model[8'(sub + i)] = d;
    end
    bus_stop();
  endtask

  task automatic read_txn(input logic [7:0] sub, input int n, input string tag);
    bit ack;
    logic [7:0] b;
    bus_start();
    write_byte(dev(0), 0, ack); chk(ack, "R5 address ack", ack, 1);
    write_byte(sub, 0, ack);    chk(ack, "R5 sub-address ack", ack, 1);
    bus_start();
    write_byte(dev(1), 0, ack); chk(ack, "R5 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[8'(sub + i)]);
      tag_q.push_back(tag);
      read_byte(i != n - 1, b);
      got = b;
      ->rd_ev;
    end
    chk(!sda_oe && sda_line, "R10 released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  task automatic port_chk(input logic [7:0] a, input string tag);
    rd_addr = a;
    repeat (2) @(negedge clk);
    chk(rd_data == model[a], tag, rd_data, model[a]);
  endtask

  initial begin
    forever begin
      @(rd_ev);
      if (exp_q.size() == 0) begin
        chk(0, "R5 unexpected read byte", got, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(got == e, t, got, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    bit ack;
    repeat (5) @(negedge clk);
    // R1: bus activity during reset gets no answer
    chk(sda_oe == 1'b0, "R1 released in reset", sda_oe, 0);
    bus_start();
    write_byte(dev(0), 0, ack);
    chk(!ack, "R1 no ack in reset", ack, 0);
    bus_stop();
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 released after reset", sda_oe, 0);

    // R3 R4: multi-byte write, parallel port observes consecutive registers
    write_txn(8'h10, 3, 8'h5A);
    port_chk(8'h10, "R3 port 0x10");
    port_chk(8'h11, "R4 port 0x11");
    port_chk(8'h12, "R4 port 0x12");

    // R5: combined read with auto-increment
    read_txn(8'h10, 3, "R5 read data");

    // R6: wrap from 0xFF to 0x00
    write_txn(8'hFE, 4, 8'hC3);
    port_chk(8'hFF, "R6 port 0xFF");
    port_chk(8'h00, "R6 port 0x00 after wrap");
    port_chk(8'h01, "R6 port 0x01 after wrap");
    read_txn(8'hFF, 3, "R6 read across wrap");

    // R7: mismatching address, following bytes ignored
    bus_start();
    write_byte({6'h23, 1'b1, 1'b0}, 0, ack); chk(!ack, "R7 foreign address nack", ack, 0);
    write_byte(8'h10, 0, ack);               chk(!ack, "R7 silent after mismatch", ack, 0);
    write_byte(8'h99, 0, ack);               chk(!ack, "R7 silent data", ack, 0);
    bus_stop();
    port_chk(8'h10, "R7 register untouched");

    // R2: strap selects the lowest address bit
    strap = 1'b1;
    repeat (4) @(negedge clk);
    write_txn(8'h20, 2, 8'h3C);
    port_chk(8'h21, "R2 write through 47h");
    bus_start();
    write_byte({6'h23, 1'b0, 1'b0}, 0, ack); chk(!ack, "R2 46h refused with strap 1", ack, 0);
    bus_stop();
    strap = 1'b0;
    repeat (4) @(negedge clk);

    // R8: START inside a data byte abandons it
    write_txn(8'h30, 1, 8'h11);
    bus_start();
    write_byte(dev(0), 0, ack);
    write_byte(8'h30, 0, ack);
    send_bits(8'hF0, 4, 0);
    write_txn(8'h40, 1, 8'h77);
    port_chk(8'h30, "R8 partial byte discarded");
    port_chk(8'h40, "R8 recovered after abort");

    // R9: short pulses on both lines during a byte
    rd_addr = 8'h50;
    bus_start();
    write_byte(dev(0), 0, ack); chk(ack, "R9 address ack", ack, 1);
    write_byte(8'h50, 0, ack);  chk(ack, "R9 sub ack", ack, 1);
    write_byte(8'hA5, 1, ack);  chk(ack, "R9 glitched byte ack", ack, 1);
    model[8'h50] = 8'hA5;
    bus_stop();
    port_chk(8'h50, "R9 glitched byte stored");
    read_txn(8'h50, 1, "R9 readback");

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule